// File: doc/BRIEF.md
# Cross-Trigger Channel Interface

This block links hardware trigger events between neighbouring devices through four shared event channels. Each of the eight trigger inputs has its own 4-bit channel mask. A high input drives every channel in its mask. Each of the eight trigger outputs also has a 4-bit mask, and the output goes high when any channel in that mask is active. A channel can be active for two reasons: it was raised locally, or it arrived on the channel-in bus from the shared matrix.

Locally raised channels go out to the matrix only through a per-channel gate. Software can also raise channels directly. It can use a persistent set/clear register, or a pulse that lasts exactly one clock. An output filter holds selected outputs low, for example a line that would halt a core.

Programming uses a simple register bus. A write is single-cycle and takes effect at the clock edge. A read is combinational from the address. The path from trigger inputs to outputs and to the matrix is combinational, so it adds no cycles.

Top module: `xtrig_chan_if`

## Requirements
- R1: While trigger input i is high, every channel whose bit is set in that input's mask is active locally. Input mask i sits at address 0x10+i, bits 3:0, and bit c is channel c.
- R2: Trigger output j is high when the block is enabled and any channel in its mask is active. The channel may be active locally or arrive on `chan_from_mtx`. Output mask j sits at address 0x18+j, bits 3:0.
- R3: `chan_to_mtx` carries the locally active channels ANDed with the gate register at 0x05, bit c for channel c. Channels that arrive from the matrix are never sent back to it.
- R4: After reset, the block is disabled and all masks are zero. The gate reads 0xF, filtering is on (0x06 bit 0 = 1), the filtered-output mask at 0x07 reads 0x01, and all outputs are low.
- R5: A write to 0x02 sets the written channel bits in a persistent software channel register. A write to 0x03 clears them. The register reads back at 0x0A and holds between writes.
- R6: A write to 0x04 makes the written channels active for exactly the one cycle after the write edge.
- R7: While filtering is on, every output whose bit is set in the mask at 0x07 stays low. With filtering off (0x06 bit 0 = 0), those outputs follow R2.
- R8: The read-only register at 0x08 shows the active channels as a bitmask (channel 2 reads 0x4). The one at 0x09 shows the high trigger outputs as a bitmask (output 6 reads 0x40).
- R9: Writing 1 to bit 0 of 0x01 restores all masks, the software channel register, the gate and the filter settings to their reset values. It leaves the enable bit unchanged.
- R10: While the enable bit (0x00 bit 0) is 0, `trig_out`, `chan_to_mtx` and both status registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 8 | Trigger inputs from devices |
| trig_out | output | 8 | Trigger outputs to devices |
| chan_from_mtx | input | 4 | Channels arriving from the matrix |
| chan_to_mtx | output | 4 | Gated local channels sent to the matrix |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |

## Verification
A wrong mask, gate or filter bit has no effect until an input or matrix channel exercises it. Once it does, it shows on `trig_out` or `chan_to_mtx` in the same cycle. A software channel that sticks or a pulse that is lost shows on the status register at 0x08 in the cycle right after the write. The random phase therefore samples the outputs and the status registers after every single write.

// File: rtl/xtrig_chan_if.sv
`timescale 1ns/1ps
module xtrig_chan_if #(
  parameter int NIN  = 8,
  parameter int NOUT = 8,
  parameter int NCH  = 4,
  parameter int AW   = 6,
  parameter int DW   = 32,
  parameter logic [NOUT-1:0] FILT_RST = {{(NOUT-1){1'b0}}, 1'b1}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIN-1:0]  trig_in,
  output logic [NOUT-1:0] trig_out,
  input  logic [NCH-1:0]  chan_from_mtx,
  output logic [NCH-1:0]  chan_to_mtx,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata
);
  localparam logic [AW-1:0] A_CTRL  = AW'(6'h00);
  localparam logic [AW-1:0] A_CMD   = AW'(6'h01);
  localparam logic [AW-1:0] A_SET   = AW'(6'h02);
  localparam logic [AW-1:0] A_CLR   = AW'(6'h03);
  localparam logic [AW-1:0] A_PULSE = AW'(6'h04);
  localparam logic [AW-1:0] A_GATE  = AW'(6'h05);
  localparam logic [AW-1:0] A_FEN   = AW'(6'h06);
  localparam logic [AW-1:0] A_FMASK = AW'(6'h07);
  localparam logic [AW-1:0] A_CHST  = AW'(6'h08);
  localparam logic [AW-1:0] A_TOST  = AW'(6'h09);
  localparam logic [AW-1:0] A_SWST  = AW'(6'h0A);
  localparam logic [AW-1:0] A_INMAP = AW'(6'h10);
  localparam logic [AW-1:0] A_OUTMP = AW'(6'h18);

  logic            en_q, fen_q;
  logic [NCH-1:0]  gate_q, sw_q, pulse_q, loc, act;
  logic [NOUT-1:0] fmask_q, tout;
  logic [NCH-1:0]  in_map  [NIN];
  logic [NCH-1:0]  out_map [NOUT];

  wire [NCH-1:0] wch = bus_wdata[NCH-1:0];
  wire do_cmd = bus_wr && bus_addr == A_CMD && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; fen_q <= 1'b1; gate_q <= '1; fmask_q <= FILT_RST;
      sw_q <= '0; pulse_q <= '0;
      for (int i = 0; i < NIN; i++)  in_map[i]  <= '0;
      for (int j = 0; j < NOUT; j++) out_map[j] <= '0;
    end else begin
      pulse_q <= '0;
      if (do_cmd) begin
        fen_q <= 1'b1; gate_q <= '1; fmask_q <= FILT_RST; sw_q <= '0;
        for (int i = 0; i < NIN; i++)  in_map[i]  <= '0;
        for (int j = 0; j < NOUT; j++) out_map[j] <= '0;
      end else if (bus_wr) begin
        if (bus_addr == A_CTRL)  en_q    <= bus_wdata[0];
        if (bus_addr == A_SET)   sw_q    <= sw_q | wch;
        if (bus_addr == A_CLR)   sw_q    <= sw_q & ~wch;
        if (bus_addr == A_PULSE) pulse_q <= wch;
        if (bus_addr == A_GATE)  gate_q  <= wch;
        if (bus_addr == A_FEN)   fen_q   <= bus_wdata[0];
        if (bus_addr == A_FMASK) fmask_q <= bus_wdata[NOUT-1:0];
        for (int i = 0; i < NIN; i++)
          if (bus_addr == A_INMAP + AW'(i)) in_map[i] <= wch;
        for (int j = 0; j < NOUT; j++)
          if (bus_addr == A_OUTMP + AW'(j)) out_map[j] <= wch;
      end
    end
  end

  always_comb begin
    loc = sw_q | pulse_q;
    for (int i = 0; i < NIN; i++)
      if (trig_in[i]) loc = loc | in_map[i];
  end

  assign act = loc | chan_from_mtx;

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    assign tout[j] = en_q & (|(out_map[j] & act)) & ~(fen_q & fmask_q[j]);
  end

  assign trig_out    = tout;
  assign chan_to_mtx = en_q ? (loc & gate_q) : '0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[0]        = en_q;
      A_GATE:  bus_rdata[NCH-1:0]  = gate_q;
      A_FEN:   bus_rdata[0]        = fen_q;
      A_FMASK: bus_rdata[NOUT-1:0] = fmask_q;
      A_CHST:  bus_rdata[NCH-1:0]  = en_q ? act : '0;
      A_TOST:  bus_rdata[NOUT-1:0] = tout;
      A_SWST:  bus_rdata[NCH-1:0]  = sw_q;
      default: ;
    endcase
    for (int i = 0; i < NIN; i++)
      if (bus_addr == A_INMAP + AW'(i)) bus_rdata[NCH-1:0] = in_map[i];
    for (int j = 0; j < NOUT; j++)
      if (bus_addr == A_OUTMP + AW'(j)) bus_rdata[NCH-1:0] = out_map[j];
  end
endmodule

module xtrig_chan_if_chk #(
  parameter int NIN = 8, parameter int NOUT = 8, parameter int NCH = 4,
  parameter int AW = 6, parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NIN-1:0]  trig_in,
  input logic [NOUT-1:0] trig_out,
  input logic [NCH-1:0]  chan_to_mtx,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            en_q,
  input logic            fen_q,
  input logic [NCH-1:0]  gate_q,
  input logic [NCH-1:0]  sw_q,
  input logic [NCH-1:0]  pulse_q,
  input logic [NOUT-1:0] fmask_q
);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (trig_out == '0 && chan_to_mtx == '0));
  p_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fen_q |-> (trig_out & fmask_q) == '0);
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_to_mtx & ~gate_q) == '0);
  p_noecho_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in == '0 && sw_q == '0 && pulse_q == '0) |-> chan_to_mtx == '0);
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(6'h04)) |=> pulse_q == '0);
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(6'h02)) |=>
      (sw_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0]));
  p_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(6'h01) && bus_wdata[0]) |=>
      (gate_q == '1 && sw_q == '0 && fen_q));
endmodule

bind xtrig_chan_if xtrig_chan_if_chk #(.NIN(NIN), .NOUT(NOUT), .NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_out(trig_out),
  .chan_to_mtx(chan_to_mtx), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .en_q(en_q), .fen_q(fen_q), .gate_q(gate_q),
  .sw_q(sw_q), .pulse_q(pulse_q), .fmask_q(fmask_q));

// File: tb/xtrig_chan_if_bench.sv
`timescale 1ns/1ps
module xtrig_chan_if_bench;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] trig_in = 0, trig_out;
  logic [3:0] chan_from_mtx = 0, chan_to_mtx;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  xtrig_chan_if u_xtrig_chan_if (.*);

  always #2.5 clk = ~clk;

  logic m_en, m_fen;
  logic [3:0] m_gate, m_sw, m_pulse;
  logic [7:0] m_fmask;
  logic [3:0] m_in [8];
  logic [3:0] m_out [8];

  function automatic void m_defaults();
    m_fen = 1; m_gate = 4'hF; m_fmask = 8'h01; m_sw = 0;
    for (int i = 0; i < 8; i++) begin m_in[i] = 0; m_out[i] = 0; end
  endfunction

  function automatic logic [3:0] f_loc();
    logic [3:0] l = m_sw | m_pulse;
    for (int i = 0; i < 8; i++) if (trig_in[i]) l |= m_in[i];
    return l;
  endfunction

  function automatic logic [7:0] f_out();
    logic [7:0] o = 0;
    logic [3:0] a = f_loc() | chan_from_mtx;
    for (int j = 0; j < 8; j++)
      o[j] = m_en & (|(m_out[j] & a)) & ~(m_fen & m_fmask[j]);
    return o;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #0.1; d = bus_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
    m_pulse = 0;
    if (a == 6'h01 && d[0]) m_defaults();
    else case (a)
      6'h00: m_en = d[0];
      6'h02: m_sw |= d[3:0];
      6'h03: m_sw &= ~d[3:0];
      6'h04: m_pulse = d[3:0];
      6'h05: m_gate = d[3:0];
      6'h06: m_fen = d[0];
      6'h07: m_fmask = d[7:0];
      default: begin
        if (a >= 6'h10 && a < 6'h18) m_in[a-6'h10] = d[3:0];
        if (a >= 6'h18 && a < 6'h20) m_out[a-6'h18] = d[3:0];
      end
    endcase
  endtask

  // full port and status comparison within the current cycle
  task automatic check_all();
    logic [31:0] d;
    logic [3:0] loc;
    #0.2;
    loc = f_loc();
    chk("R2 trig_out", trig_out, f_out());
    chk("R3 chan_to_mtx", chan_to_mtx, m_en ? loc & m_gate : 4'h0);
    rd(6'h08, d); chk("R8/R1 chan status", d, m_en ? loc | chan_from_mtx : 0);
    rd(6'h09, d); chk("R8 trig status", d, f_out());
    rd(6'h0A, d); chk("R5 sw readback", d, m_sw);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin n_chk++; n_fail++; $display("FAIL watchdog: got timeout expected done"); finish_run(); end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed));
    m_en = 0; m_pulse = 0; m_defaults();
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R4 reset state
    chk("R4 trig_out", trig_out, 0);
    rd(6'h05, d); chk("R4 gate", d, 32'hF);
    rd(6'h06, d); chk("R4 filter on", d, 1);
    rd(6'h07, d); chk("R4 filter mask", d, 32'h01);
    rd(6'h13, d); chk("R4 in map", d, 0);
    wr(6'h00, 1);
    trig_in = 8'hFF; chan_from_mtx = 4'h0;
    #0.2; chk("R4 unprogrammed outputs", trig_out, 0);
    chk("R4 unprogrammed mtx", chan_to_mtx, 0);
    trig_in = 0;
    // R1 R8: input 1 -> ch2 -> output 6
    wr(6'h11, 4'h4); wr(6'h1E, 4'h4);
    trig_in = 8'h02;
    #0.2; rd(6'h08, d); chk("R8 ch2 reads 0x4", d, 32'h4);
    rd(6'h09, d); chk("R8 out6 reads 0x40", d, 32'h40);
    chk("R1 to matrix", chan_to_mtx, 4'h4);
    check_all();
    // R3 gate closes ch2
    wr(6'h05, 4'hB);
    #0.2; chk("R3 gated", chan_to_mtx, 0); chk("R3 local still drives", trig_out, 8'h40);
    // R2 from matrix only, R3 no echo
    wr(6'h05, 4'hF); trig_in = 0; chan_from_mtx = 4'h4;
    #0.2; chk("R2 from matrix", trig_out, 8'h40); chk("R3 no echo", chan_to_mtx, 0);
    chan_from_mtx = 0;
    // R5 persistent set/clear
    wr(6'h02, 4'h4);
    repeat (3) @(negedge clk);
    #0.2; chk("R5 set holds", trig_out, 8'h40);
    wr(6'h03, 4'h4);
    #0.2; chk("R5 cleared", trig_out, 0);
    // R6 single-cycle pulse
    wr(6'h04, 4'h4);
    #0.2; chk("R6 pulse cycle", trig_out, 8'h40);
    m_pulse = 0;
    @(negedge clk); #0.2; chk("R6 pulse gone", trig_out, 0);
    // R7 filter on output 0
    wr(6'h10, 4'h1); wr(6'h18, 4'h1); trig_in = 8'h01;
    #0.2; chk("R7 filtered", trig_out[0], 0);
    wr(6'h06, 0);
    #0.2; chk("R7 unfiltered", trig_out[0], 1);
    // R10 disable
    wr(6'h00, 0);
    #0.2; chk("R10 outputs", trig_out, 0); chk("R10 mtx", chan_to_mtx, 0);
    rd(6'h08, d); chk("R10 status", d, 0);
    wr(6'h00, 1);
    // R9 reset command
    wr(6'h02, 4'h3); wr(6'h05, 4'h1);
    wr(6'h01, 1);
    rd(6'h10, d); chk("R9 in map cleared", d, 0);
    rd(6'h05, d); chk("R9 gate restored", d, 32'hF);
    rd(6'h06, d); chk("R9 filter restored", d, 1);
    rd(6'h00, d); chk("R9 enable kept", d, 1);
    check_all();
    // random phase
    for (int k = 0; k < 800; k++) begin
      int r = $urandom_range(0, 99);
      logic [5:0] a;
      logic [31:0] v = $urandom;
      if (r < 2) a = 6'h01;
      else if (r < 8) begin a = 6'h00; v[0] = ($urandom_range(0, 9) != 0); end
      else if (r < 40) a = 6'h10 + 6'($urandom_range(0, 7));
      else if (r < 70) a = 6'h18 + 6'($urandom_range(0, 7));
      else a = 6'($urandom_range(2, 7));
      wr(a, v);
      trig_in = 8'($urandom); chan_from_mtx = 4'($urandom);
      if ($urandom_range(0, 3) == 0) trig_in = 0;
      check_all();
    end
    done = 1;
    finish_run();
  end
endmodule